// File: doc/BRIEF.md
# Serial Wiper Command Decoder with Write Protection

This block takes 16-bit command frames from a three-wire serial port (an active-low frame select, a serial clock and a data line) and turns them into actions on a 10-bit wiper setting register. It also keeps a small control word made of three bits: one that allows nonvolatile stores, one that allows wiper writes, and one that reports whether the last store succeeded. Its outputs are the wiper value, a shutdown flag, a store request to a nonvolatile-memory controller, and a read request that hands an output shifter the word it should send in the next frame.

The serial clock is unrelated to the system clock. Bits are captured on the falling serial clock edge while the frame select is low. The frame select and the finished frame are carried into the system clock domain, and a frame is decoded there only if its clock count is a nonzero multiple of 16. Frames with any other count, frames with no clocks, and frames that end while a store is outstanding are dropped. When more than 16 bits are clocked in, only the last 16 count. Bits 15:14 of a frame are don't-care, bits 13:10 carry the command, and bits 9:0 carry the data.

Top module: `wiper_cmd_decoder`

## Requirements
- R1: After reset the wiper holds midscale (512), shutdown is 0, store enable, write enable and the success bit are 0, and no request strobe is asserted.
- R2: A frame is executed only if the number of falling serial clock edges while the frame select is low is a nonzero multiple of 16. When there are more than 16 edges, the last 16 bits form the frame. A frame with any other count, or with no clock edges, has no effect.
- R3: Command 1 loads data bits 9:0 into the wiper only when write enable is 1. Otherwise the wiper is unchanged.
- R4: Command 7 sets store enable from data bit 0 and write enable from data bit 1. Data bit 3, the success bit, cannot be written this way.
- R5: Commands 2, 5, 6 and 8 each raise rdReq for exactly one cycle, with rdSrc and rdWord as follows:
  - command 2: rdSrc = 0, rdWord = the wiper.
  - command 5: rdSrc = 1, rdWord = data bits 5:0 with the upper bits zero.
  - command 6: rdSrc = 2, rdWord = 0.
  - command 8: rdSrc = 3, rdWord = the control word (bit 0 = store enable, bit 1 = write enable, bit 3 = success, all other bits 0).
- R6: Command 3 raises storeReq for one cycle only when store enable is 1. It clears the success bit and marks a store as outstanding. A storeDone pulse ends the store, and the success bit then takes the value of storeOk.
- R7: Every frame that completes while a store is outstanding is dropped.
- R8: Command 4 loads nvmWord into the wiper even when write enable is 0, and it clears shutdown.
- R9: Command 9 sets shutdown to data bit 0. All other commands still work while shutdown is 1.
- R10: Command 0 and the codes 10 to 15 change neither the outputs nor the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| syncN | input | 1 | Active-low frame select; its rising edge ends a frame |
| din | input | 1 | Serial data, most significant bit first |
| nvmWord | input | 10 | Last stored wiper value from the memory controller (midscale if nothing has been stored) |
| storeDone | input | 1 | One-cycle pulse that ends an outstanding store |
| storeOk | input | 1 | Result of the store, valid together with storeDone |
| wiper | output | 10 | Wiper setting register |
| shutdown | output | 1 | Shutdown flag |
| storeReq | output | 1 | One-cycle request to store the wiper into nonvolatile memory |
| rdReq | output | 1 | One-cycle request to load the output shifter |
| rdSrc | output | 2 | Readback source: 0 wiper, 1 memory location, 2 last-address, 3 control |
| rdWord | output | 10 | Value or memory address handed to the output shifter |

## Verification
If the protection bits are wrong, the error stays hidden until a wiper write or a store arrives. Then the wiper takes a value it should have refused, or refuses one it should have taken. A command 8 read shows the bits directly, one frame later. An error in the clock-count check or in the new-frame detection shows up only on frames of the wrong length, or when the frame select is pulsed with no clocks. For that reason, frames of 0, 15, 17 and 32 clocks are sent and the wiper is compared on every clock once the frame has settled. A store flag that stays set never makes itself visible directly. It appears as the next frame being silently dropped, so a write is sent during the store and another after storeDone.

// File: rtl/wipdec_pkg.sv
package wipdec_pkg;
  localparam int WORD_W  = 10;
  localparam int CMD_W   = 4;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 6;
  localparam int BODY_W  = CMD_W + WORD_W;

  localparam int BIT_PROG = 0;
  localparam int BIT_WREN = 1;
  localparam int BIT_OK   = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP      = 4'd0,
    CMD_WR_WIPER = 4'd1,
    CMD_RD_WIPER = 4'd2,
    CMD_STORE    = 4'd3,
    CMD_REFRESH  = 4'd4,
    CMD_RD_MEM   = 4'd5,
    CMD_RD_LAST  = 4'd6,
    CMD_WR_CTRL  = 4'd7,
    CMD_RD_CTRL  = 4'd8,
    CMD_SHUTDOWN = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    SRC_WIPER = 2'd0,
    SRC_MEM   = 2'd1,
    SRC_LAST  = 2'd2,
    SRC_CTRL  = 2'd3
  } rdsrc_e;

  typedef struct packed {
    logic              wrWiper;
    logic              loadNvm;
    logic              wrCtrl;
    logic              sdWrite;
    logic              store;
    logic              rd;
    rdsrc_e            rdSrc;
    logic [WORD_W-1:0] data;
    logic [WORD_W-1:0] rdWord;
  } strobe_t;
endpackage

// File: rtl/wipdec_serial.sv
module wipdec_serial #(
  parameter int FRAME_W = 16,
  parameter int BODY_W  = 14
) (
  input  logic              rstN,
  input  logic              sclk,
  input  logic              syncN,
  input  logic              din,
  output logic [BODY_W-1:0] body,
  output logic              aligned,
  output logic              tag
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [CNT_W-1:0] bitCnt;
  logic             inFrame;

  // position inside the current 16-bit slot, cleared whenever the frame ends
  always_ff @(negedge sclk or posedge syncN) begin
    if (syncN) begin
      bitCnt  <= '0;
      inFrame <= 1'b0;
    end else begin
      inFrame <= 1'b1;
      if (bitCnt == CNT_W'(FRAME_W - 1)) bitCnt <= '0;
      else                               bitCnt <= bitCnt + 1'b1;
    end
  end

  // alignment flag and a toggle that marks each new frame with clocks
  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN) begin
      aligned <= 1'b0;
      tag     <= 1'b0;
    end else if (!syncN) begin
      aligned <= (bitCnt == CNT_W'(FRAME_W - 1));
      tag     <= tag ^ !inFrame;
    end
  end

  always_ff @(negedge sclk) begin
    if (!syncN) body <= {body[BODY_W-2:0], din};
  end
endmodule

// File: rtl/wipdec_xfer.sv
module wipdec_xfer #(
  parameter int BODY_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncN,
  input  logic              tag,
  input  logic              aligned,
  input  logic [BODY_W-1:0] bodyIn,
  output logic              frameValid,
  output logic [BODY_W-1:0] bodyOut
);
  logic [SYNC_STAGES:0] syncPipe;
  logic                 seenTag;
  logic                 syncRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '1;
    else       syncPipe <= {syncPipe[SYNC_STAGES-1:0], syncN};
  end

  assign syncRise = syncPipe[SYNC_STAGES-1] & ~syncPipe[SYNC_STAGES];

  // serial-side state is frozen while select is high, so it is safe to read here
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         seenTag <= 1'b0;
    else if (syncRise) seenTag <= tag;
  end

  assign frameValid = syncRise && (tag != seenTag) && aligned;
  assign bodyOut    = bodyIn;
endmodule

// File: rtl/wipdec_ctrl.sv
module wipdec_ctrl
  import wipdec_pkg::*;
(
  input  logic              frameValid,
  input  logic [BODY_W-1:0] body,
  input  logic              busy,
  input  logic              progEn,
  input  logic              wrEn,
  input  logic              okBit,
  input  logic [WORD_W-1:0] wiper,
  output strobe_t           stb
);
  cmd_e              cmd;
  logic [WORD_W-1:0] ctrlWord;

  assign cmd = cmd_e'(body[BODY_W-1:WORD_W]);

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[BIT_PROG] = progEn;
    ctrlWord[BIT_WREN] = wrEn;
    ctrlWord[BIT_OK]   = okBit;
  end

  always_comb begin
    stb      = '0;
    stb.data = body[WORD_W-1:0];
    if (frameValid && !busy) begin
      unique case (cmd)
        CMD_WR_WIPER: stb.wrWiper = wrEn;
        CMD_RD_WIPER: begin
          stb.rd     = 1'b1;
          stb.rdSrc  = SRC_WIPER;
          stb.rdWord = wiper;
        end
        CMD_STORE:    stb.store = progEn;
        CMD_REFRESH:  stb.loadNvm = 1'b1;
        CMD_RD_MEM: begin
          stb.rd     = 1'b1;
          stb.rdSrc  = SRC_MEM;
          stb.rdWord = WORD_W'(body[ADDR_W-1:0]);
        end
        CMD_RD_LAST: begin
          stb.rd    = 1'b1;
          stb.rdSrc = SRC_LAST;
        end
        CMD_WR_CTRL:  stb.wrCtrl = 1'b1;
        CMD_RD_CTRL: begin
          stb.rd     = 1'b1;
          stb.rdSrc  = SRC_CTRL;
          stb.rdWord = ctrlWord;
        end
        CMD_SHUTDOWN: stb.sdWrite = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wipdec_dpath.sv
module wipdec_dpath
  import wipdec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] nvmWord,
  input  logic              storeDone,
  input  logic              storeOk,
  output logic [WORD_W-1:0] wiper,
  output logic              shutdown,
  output logic              progEn,
  output logic              wrEn,
  output logic              okBit,
  output logic              busy,
  output logic              storeReq,
  output logic              rdReq,
  output rdsrc_e            rdSrc,
  output logic [WORD_W-1:0] rdWord
);
  localparam logic [WORD_W-1:0] MID = WORD_W'(1) << (WORD_W - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wiper    <= MID;
      shutdown <= 1'b0;
      progEn   <= 1'b0;
      wrEn     <= 1'b0;
      okBit    <= 1'b0;
      busy     <= 1'b0;
      storeReq <= 1'b0;
      rdReq    <= 1'b0;
      rdSrc    <= SRC_WIPER;
      rdWord   <= '0;
    end else begin
      storeReq <= stb.store;
      rdReq    <= stb.rd;
      if (stb.rd) begin
        rdSrc  <= stb.rdSrc;
        rdWord <= stb.rdWord;
      end
      if (stb.wrWiper)      wiper <= stb.data;
      else if (stb.loadNvm) wiper <= nvmWord;
      if (stb.loadNvm)      shutdown <= 1'b0;
      else if (stb.sdWrite) shutdown <= stb.data[0];
      if (stb.wrCtrl) begin
        progEn <= stb.data[BIT_PROG];
        wrEn   <= stb.data[BIT_WREN];
      end
      if (stb.store) begin
        busy  <= 1'b1;
        okBit <= 1'b0;
      end else if (storeDone && busy) begin
        busy  <= 1'b0;
        okBit <= storeOk;
      end
    end
  end
endmodule

// File: rtl/wiper_cmd_decoder.sv
module wiper_cmd_decoder
  import wipdec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              syncN,
  input  logic              din,
  input  logic [WORD_W-1:0] nvmWord,
  input  logic              storeDone,
  input  logic              storeOk,
  output logic [WORD_W-1:0] wiper,
  output logic              shutdown,
  output logic              storeReq,
  output logic              rdReq,
  output logic [1:0]        rdSrc,
  output logic [WORD_W-1:0] rdWord
);
  logic [BODY_W-1:0] serBody;
  logic [BODY_W-1:0] sysBody;
  logic              serAligned;
  logic              serTag;
  logic              frameValid;
  logic              busy;
  logic              progEn;
  logic              wrEn;
  logic              okBit;
  rdsrc_e            rdSrcE;
  strobe_t           stb;

  wipdec_serial #(.FRAME_W(FRAME_W), .BODY_W(BODY_W)) u_serial (
    .rstN(rstN), .sclk(sclk), .syncN(syncN), .din(din),
    .body(serBody), .aligned(serAligned), .tag(serTag)
  );

  wipdec_xfer #(.BODY_W(BODY_W), .SYNC_STAGES(2)) u_xfer (
    .clk(clk), .rstN(rstN), .syncN(syncN), .tag(serTag),
    .aligned(serAligned), .bodyIn(serBody),
    .frameValid(frameValid), .bodyOut(sysBody)
  );

  wipdec_ctrl u_ctrl (
    .frameValid(frameValid), .body(sysBody), .busy(busy),
    .progEn(progEn), .wrEn(wrEn), .okBit(okBit), .wiper(wiper), .stb(stb)
  );

  wipdec_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .nvmWord(nvmWord),
    .storeDone(storeDone), .storeOk(storeOk),
    .wiper(wiper), .shutdown(shutdown), .progEn(progEn), .wrEn(wrEn),
    .okBit(okBit), .busy(busy), .storeReq(storeReq), .rdReq(rdReq),
    .rdSrc(rdSrcE), .rdWord(rdWord)
  );

  assign rdSrc = rdSrcE;
endmodule

// File: rtl/wiper_cmd_decoder_chk.sv
module wiper_cmd_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic [9:0] wiper,
  input logic       shutdown,
  input logic       storeReq,
  input logic       rdReq,
  input logic       busy,
  input logic       progEn,
  input logic       wrEn,
  input logic       stbWrWiper,
  input logic       stbLoadNvm,
  input logic       stbAny
);
  AST_WIPER_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (wiper != $past(wiper)) |-> $past(stbWrWiper || stbLoadNvm)); // R3
  AST_WRITE_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    stbWrWiper |-> wrEn); // R3
  AST_STORE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> $past(progEn)); // R6
  AST_STORE_LOCKOUT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stbAny); // R7
  AST_REFRESH_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    $past(stbLoadNvm) |-> !shutdown); // R8
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq); // R5
endmodule

bind wiper_cmd_decoder wiper_cmd_decoder_chk u_chk (
  .clk(clk), .rstN(rstN), .wiper(wiper), .shutdown(shutdown),
  .storeReq(storeReq), .rdReq(rdReq), .busy(busy), .progEn(progEn),
  .wrEn(wrEn), .stbWrWiper(stb.wrWiper), .stbLoadNvm(stb.loadNvm),
  .stbAny(stb.wrWiper | stb.loadNvm | stb.wrCtrl | stb.sdWrite | stb.store | stb.rd)
);

// File: tb/wiper_cmd_decoder_tb.sv
module wiper_cmd_decoder_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclk = 1'b0;
  logic       syncN = 1'b1;
  logic       din = 1'b0;
  logic [9:0] nvmWord = 10'h200;
  logic       storeDone = 1'b0;
  logic       storeOk = 1'b0;
  logic [9:0] wiper;
  logic       shutdown;
  logic       storeReq;
  logic       rdReq;
  logic [1:0] rdSrc;
  logic [9:0] rdWord;

  int nChecks = 0;
  int nFails = 0;

  // behavioural reference state
  logic [9:0]  mWiper = 10'h200;
  logic        mSd = 1'b0, mProg = 1'b0, mWr = 1'b0, mOk = 1'b0, mBusy = 1'b0;
  int          expStores = 0, actStores = 0;
  logic [11:0] expQ[$];
  logic [11:0] actQ[$];
  bit          settled = 1'b0;

  wiper_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .syncN(syncN), .din(din),
    .nvmWord(nvmWord), .storeDone(storeDone), .storeOk(storeOk),
    .wiper(wiper), .shutdown(shutdown), .storeReq(storeReq), .rdReq(rdReq),
    .rdSrc(rdSrc), .rdWord(rdWord)
  );

  always #10 clk = ~clk;

  task automatic fin();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog (all reqs) actual=expired expected=finished");
    fin();
  end

  // outputs compared against the model on every settled clock
  always @(negedge clk) begin
    if (rdReq) actQ.push_back({rdSrc, rdWord});
    if (storeReq) actStores++;
    if (settled) begin
      nChecks++;
      if (wiper !== mWiper || shutdown !== mSd) begin
        nFails++;
        $display("FAIL state R3 R8 R9 actual=%h/%b expected=%h/%b", wiper, shutdown, mWiper, mSd);
      end
    end
  end

  task automatic mExec(input logic [15:0] w);
    logic [9:0] d;
    d = w[9:0];
    if (mBusy) return;
    case (w[13:10])
      4'd1: if (mWr) mWiper = d;
      4'd2: expQ.push_back({2'd0, mWiper});
      4'd3: if (mProg) begin mBusy = 1'b1; mOk = 1'b0; expStores++; end
      4'd4: begin mWiper = nvmWord; mSd = 1'b0; end
      4'd5: expQ.push_back({2'd1, 4'd0, d[5:0]});
      4'd6: expQ.push_back({2'd2, 10'd0});
      4'd7: begin mProg = d[0]; mWr = d[1]; end
      4'd8: expQ.push_back({2'd3, 6'd0, mOk, 1'b0, mWr, mProg});
      4'd9: mSd = d[0];
      default: ;
    endcase
  endtask

  task automatic sendBits(input logic [31:0] bits, input int n, input bit exec);
    settled = 1'b0;
    @(negedge clk);
    syncN = 1'b0;
    #30;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b1; din = bits[i]; #40;
      sclk = 1'b0; #40;
    end
    #20 syncN = 1'b1;
    repeat (8) @(negedge clk);
    if (exec) mExec(bits[15:0]);
    #1 settled = 1'b1;
  endtask

  task automatic frame(input logic [15:0] w);
    sendBits({16'd0, w}, 16, 1'b1);
  endtask

  task automatic checkSide(input string rq);
    nChecks++;
    if (actStores != expStores) begin
      nFails++;
      $display("FAIL %s storeReq count actual=%0d expected=%0d", rq, actStores, expStores);
    end
    nChecks++;
    if (actQ.size() != expQ.size()) begin
      nFails++;
      $display("FAIL %s read count actual=%0d expected=%0d", rq, actQ.size(), expQ.size());
    end else begin
      foreach (actQ[i]) if (actQ[i] !== expQ[i]) begin
        nFails++;
        $display("FAIL %s read word actual=%h expected=%h", rq, actQ[i], expQ[i]);
      end
    end
    actQ.delete();
    expQ.delete();
  endtask

  task automatic finishStore(input logic ok);
    @(negedge clk);
    storeDone = 1'b1; storeOk = ok;
    @(negedge clk);
    storeDone = 1'b0;
    mBusy = 1'b0; mOk = ok;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    settled = 1'b1;
    // R1 reset state
    nChecks++;
    if (wiper !== 10'h200 || shutdown !== 1'b0 || rdReq !== 1'b0 || storeReq !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset actual=%h/%b expected=200/0", wiper, shutdown);
    end
    frame(16'h2000); checkSide("R1");                  // control reads 0
    frame(16'h0555); checkSide("R3");                  // protected write ignored
    frame(16'h1C0B); frame(16'h2000); checkSide("R4"); // bit3 not writable
    frame(16'h0555); frame(16'h0800); checkSide("R5");
    // R2 bad counts: 15, 17, none
    sendBits({16'd0, 16'h04AA}, 15, 1'b0); checkSide("R2");
    sendBits({15'd0, 1'b0, 16'h04AA}, 17, 1'b0); checkSide("R2");
    sendBits(32'd0, 0, 1'b0); checkSide("R2");
    sendBits({16'h07FF, 16'h0422}, 32, 1'b1); checkSide("R2");
    // R9 shutdown and commands inside it
    frame(16'h2401); frame(16'h0500); frame(16'h0800); checkSide("R9");
    frame(16'h2400); frame(16'h2401); checkSide("R9");
    // R8 refresh
    nvmWord = 10'h2C7; frame(16'h1000); checkSide("R8");
    frame(16'h1C00); nvmWord = 10'h0F0; frame(16'h1000); frame(16'h0511); checkSide("R8");
    frame(16'h1C03);
    // R6 / R7 store flow
    frame(16'h0C00); checkSide("R6");
    frame(16'h0411); frame(16'h2000); checkSide("R7");
    finishStore(1'b1); frame(16'h2000); frame(16'h0411); checkSide("R6");
    frame(16'h0C00); finishStore(1'b0); frame(16'h2000); checkSide("R6");
    frame(16'h1C02); frame(16'h0C00); frame(16'h2000); checkSide("R6");
    // R5 other reads, R10 no-ops
    frame(16'h17D4); frame(16'h1800); checkSide("R5");
    frame(16'h0000); frame(16'h3FFF); frame(16'h2BFF); frame(16'h2000); checkSide("R10");
    fin();
  end
endmodule